// File: doc/BRIEF.md
# Coprocessor Memory Hazard Interlock

This block guards the issue stage of a pipeline where a vector coprocessor and a floating-point coprocessor share one memory port. Each cycle it is offered a pre-decoded descriptor for the next instruction. The descriptor gives the issuing unit and whether the instruction reads or writes memory. The block keeps a short record of the memory operations in the slots it has already issued. It holds back any instruction that would form an unsafe pair with an earlier operation, and it fills the gap with bubbles. Two cases are unsafe: a coprocessor read directly after a read by the other coprocessor, and a coprocessor write too close after a write by the other coprocessor. Addresses play no part in this decision.

The descriptor interface is valid/ready. `dsc_ready` is the issue enable. It may depend on the descriptor payload. While `dsc_valid` is high and `dsc_ready` is low, the source must keep the descriptor unchanged. The instruction issues in the first cycle where `dsc_valid` and `dsc_ready` are both high. `pipe_stall` freezes the pipeline: nothing issues, no bubble is inserted and the record does not move. A stall also marks the youngest recorded operation as having been stalled. With `cfg_stall_qual` high, only recorded operations that saw such a stall can cause a conflict. With it low, every matching pair causes one.

Top module: `hz_interlock`

## Requirements
- R1: Synchronous active-high `rst` empties the record, so the first valid descriptor after reset is accepted (`dsc_ready`=1) unless `pipe_stall` is high.
- R2: A coprocessor read offered right after the other coprocessor issued a read is refused with one bubble. It is accepted in the following slot.
- R3: A coprocessor write is refused while either of the last two slots holds a write from the other coprocessor, so a back-to-back pair costs two bubbles.
- R4: Detection is symmetric: vector-then-float and float-then-vector give identical results.
- R5: A read after a write, or a write after a read, across the two coprocessors never refuses. Neither does a same-type access from the same coprocessor.
- R6: Any slot that is not a coprocessor read separates reads, including a coprocessor write. Any slot that is not a coprocessor write separates writes. Bubbles and empty slots count as separators.
- R7: While `pipe_stall`=1, `dsc_ready`=0 and `bubble_ins`=0, and the record is frozen. Stall cycles do not count as separation.
- R8: With `cfg_stall_qual`=1, a pair conflicts only if the earlier operation was the youngest record entry during a `pipe_stall` cycle. With `cfg_stall_qual`=0, every pair of the kinds in R2 and R3 conflicts.
- R9: `bubble_ins`=1 exactly when `dsc_valid`=1, a conflict exists and `pipe_stall`=0. When `dsc_valid`=0 the payload is ignored and `dsc_ready`=1 (unless stalled). A refused descriptor must be held stable.
- R10: Unit code 2'b01 is vector and 2'b10 is floating point. Codes 2'b00 and 2'b11 are other units: their memory accesses never conflict and they count as separators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stall_qual | input | 1 | 1: conflicts only after a stalled access; 0: always |
| pipe_stall | input | 1 | Pipeline frozen this cycle; marks youngest issued op as stalled |
| dsc_valid | input | 1 | Descriptor present |
| dsc_ready | output | 1 | Issue enable for the offered descriptor |
| dsc_unit | input | 2 | Issuing unit code (see R10) |
| dsc_rd | input | 1 | Instruction reads memory |
| dsc_wr | input | 1 | Instruction writes memory |
| bubble_ins | output | 1 | A bubble is inserted this cycle |

## Verification
The read-read and write-write pairs are driven in both unit orders. These cases show that each access type has its own window of one or two slots, and that the check is symmetric. Mixed-direction pairs, same-unit pairs and other-unit codes each come straight after a coprocessor access. In these cases no bubble must appear, which separates a correct pair match from a check on unit or direction alone. Separator sequences use an opposite-direction coprocessor access, an empty slot, or a single slot where two are needed, to find the exact slot where issue resumes. Stall sequences are run in both configuration modes. They show whether stall cycles freeze the record and whether the stall mark arms the qualified check.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    UNIT_OTHER = 2'd0,
    UNIT_VEC   = 2'd1,
    UNIT_FLT   = 2'd2,
    UNIT_RSVD  = 2'd3
  } unit_e;

  // One issued slot as remembered by the interlock.
  typedef struct packed {
    logic rd;       // coprocessor memory read
    logic wr;       // coprocessor memory write
    logic side;     // 0: vector, 1: floating point
    logic stalled;  // saw a pipeline stall while youngest
  } slot_t;

  function automatic slot_t make_slot(input logic [1:0] unit, input logic rd,
                                      input logic wr);
    slot_t s;
    logic  cop;
    cop       = (unit == UNIT_VEC) || (unit == UNIT_FLT);
    s.rd      = cop & rd;
    s.wr      = cop & wr;
    s.side    = (unit == UNIT_FLT);
    s.stalled = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/hz_history.sv
module hz_history #(
  parameter int DEPTH = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          advance,
  input  logic                          mark_stall,
  input  hz_pkg::slot_t                 new_slot,
  output hz_pkg::slot_t [DEPTH-1:0]     hist
);
  hz_pkg::slot_t [DEPTH-1:0] hist_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)             hist_q[0] <= '0;
        else if (advance)    hist_q[0] <= new_slot;
        else if (mark_stall) hist_q[0].stalled <= 1'b1;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)          hist_q[i] <= '0;
        else if (advance) hist_q[i] <= hist_q[i-1];
      end
    end
  end

  assign hist = hist_q;
endmodule

// File: rtl/hz_detect.sv
module hz_detect #(
  parameter int DEPTH  = 2,
  parameter int RD_GAP = 1,
  parameter int WR_GAP = 2
) (
  input  hz_pkg::slot_t [DEPTH-1:0] hist,
  input  logic                      cand_rd,
  input  logic                      cand_wr,
  input  logic                      cand_side,
  input  logic                      stall_qual,
  output logic                      hazard
);
  logic [DEPTH-1:0] rd_hit;
  logic [DEPTH-1:0] wr_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    localparam logic RD_WIN = (i < RD_GAP);
    localparam logic WR_WIN = (i < WR_GAP);
    logic opp;
    logic armed;
    assign opp       = hist[i].side != cand_side;
    assign armed     = !stall_qual || hist[i].stalled;
    assign rd_hit[i] = RD_WIN && cand_rd && hist[i].rd && opp && armed;
    assign wr_hit[i] = WR_WIN && cand_wr && hist[i].wr && opp && armed;
  end

  assign hazard = (|rd_hit) || (|wr_hit);
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int RD_GAP = 1,
  parameter int WR_GAP = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_stall_qual,
  input  logic       pipe_stall,
  input  logic       dsc_valid,
  output logic       dsc_ready,
  input  logic [1:0] dsc_unit,
  input  logic       dsc_rd,
  input  logic       dsc_wr,
  output logic       bubble_ins
);
  localparam int HIST_DEPTH = (RD_GAP > WR_GAP) ? RD_GAP : WR_GAP;

  hz_pkg::slot_t                  cand;
  hz_pkg::slot_t                  new_slot;
  hz_pkg::slot_t [HIST_DEPTH-1:0] hist;
  logic                           hazard;
  logic                           issue;

  assign cand     = dsc_valid ? hz_pkg::make_slot(dsc_unit, dsc_rd, dsc_wr) : '0;
  assign issue    = dsc_valid && dsc_ready;
  assign new_slot = issue ? cand : '0;

  hz_detect #(
    .DEPTH (HIST_DEPTH),
    .RD_GAP(RD_GAP),
    .WR_GAP(WR_GAP)
  ) i_detect (
    .hist      (hist),
    .cand_rd   (cand.rd),
    .cand_wr   (cand.wr),
    .cand_side (cand.side),
    .stall_qual(cfg_stall_qual),
    .hazard    (hazard)
  );

  hz_history #(
    .DEPTH(HIST_DEPTH)
  ) i_history (
    .clk       (clk),
    .rst       (rst),
    .advance   (!pipe_stall),
    .mark_stall(pipe_stall),
    .new_slot  (new_slot),
    .hist      (hist)
  );

  assign dsc_ready  = !pipe_stall && !hazard;
  assign bubble_ins = !pipe_stall && dsc_valid && hazard;
endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_stall_qual,
  input logic       pipe_stall,
  input logic       dsc_valid,
  input logic       dsc_ready,
  input logic [1:0] dsc_unit,
  input logic       dsc_rd,
  input logic       dsc_wr,
  input logic       bubble_ins
);
  logic cop;
  logic side;
  logic prev_rd;
  logic prev_wr;
  logic prev_side;

  assign cop  = (dsc_unit == 2'd1) || (dsc_unit == 2'd2);
  assign side = (dsc_unit == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_rd   <= 1'b0;
      prev_wr   <= 1'b0;
      prev_side <= 1'b0;
    end else begin
      prev_rd   <= dsc_valid && dsc_ready && cop && dsc_rd;
      prev_wr   <= dsc_valid && dsc_ready && cop && dsc_wr;
      prev_side <= side;
    end
  end

  AST_FIRST_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && dsc_valid && !pipe_stall |-> dsc_ready);  // R1

  AST_RD_SPACING: assert property (@(posedge clk) disable iff (rst)
    !cfg_stall_qual && !pipe_stall && dsc_valid && cop && dsc_rd &&
    prev_rd && (prev_side != side) |-> !dsc_ready);  // R2

  AST_WR_SPACING: assert property (@(posedge clk) disable iff (rst)
    !cfg_stall_qual && !pipe_stall && dsc_valid && cop && dsc_wr &&
    prev_wr && (prev_side != side) |-> !dsc_ready);  // R3

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    pipe_stall |-> !dsc_ready && !bubble_ins);  // R7

  AST_BUBBLE_QUAL: assert property (@(posedge clk) disable iff (rst)
    bubble_ins |-> dsc_valid && !dsc_ready && !pipe_stall);  // R9

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_unit) &&
    $stable(dsc_rd) && $stable(dsc_wr));  // R9
endmodule

bind hz_interlock hz_interlock_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_stall_qual(cfg_stall_qual),
  .pipe_stall    (pipe_stall),
  .dsc_valid     (dsc_valid),
  .dsc_ready     (dsc_ready),
  .dsc_unit      (dsc_unit),
  .dsc_rd        (dsc_rd),
  .dsc_wr        (dsc_wr),
  .bubble_ins    (bubble_ins)
);

// File: tb/test_hz_interlock.sv
module test_hz_interlock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_stall_qual = 1'b0;
  logic       pipe_stall = 1'b0;
  logic       dsc_valid = 1'b0;
  logic       dsc_ready;
  logic [1:0] dsc_unit = 2'd0;
  logic       dsc_rd = 1'b0;
  logic       dsc_wr = 1'b0;
  logic       bubble_ins;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [1:0] U_O = 2'd0, U_V = 2'd1, U_F = 2'd2, U_X = 2'd3;

  always #4 clk = ~clk;

  hz_interlock i_hz_interlock (
    .clk(clk), .rst(rst), .cfg_stall_qual(cfg_stall_qual),
    .pipe_stall(pipe_stall), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
    .dsc_unit(dsc_unit), .dsc_rd(dsc_rd), .dsc_wr(dsc_wr),
    .bubble_ins(bubble_ins)
  );

  // Drive one slot at the falling edge, check outputs before the next rising edge.
  task automatic slot(input logic v, input logic [1:0] u, input logic r,
                      input logic w, input logic st, input logic exp_rdy,
                      input logic exp_bub, input string req);
    @(negedge clk);
    dsc_valid = v; dsc_unit = u; dsc_rd = r; dsc_wr = w; pipe_stall = st;
    #1;
    n_cmp++;
    if (dsc_ready !== exp_rdy || bubble_ins !== exp_bub) begin
      n_bad++;
      $display("FAIL %s: ready/bubble got %b/%b expected %b/%b", req,
               dsc_ready, bubble_ins, exp_rdy, exp_bub);
    end
  endtask

  task automatic do_reset(input logic qual);
    @(negedge clk);
    rst = 1'b1; cfg_stall_qual = qual; dsc_valid = 1'b0; pipe_stall = 1'b0;
    dsc_unit = U_O; dsc_rd = 1'b0; dsc_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    slot(1, U_F, 1, 0, 0, 1, 0, "R1 first after reset");
  endtask

  task automatic t_read_pair();
    do_reset(1'b0);
    slot(1, U_V, 1, 0, 0, 1, 0, "R2 first read");
    slot(1, U_F, 1, 0, 0, 0, 1, "R2 back-to-back read refused");
    slot(1, U_F, 1, 0, 0, 1, 0, "R2 read after one bubble");
    do_reset(1'b0);
    slot(1, U_F, 1, 0, 0, 1, 0, "R4 float read");
    slot(1, U_V, 1, 0, 0, 0, 1, "R4 vector read refused");
    slot(1, U_V, 1, 0, 0, 1, 0, "R4 vector read issues");
  endtask

  task automatic t_write_pair();
    do_reset(1'b0);
    slot(1, U_V, 0, 1, 0, 1, 0, "R3 first write");
    slot(1, U_F, 0, 1, 0, 0, 1, "R3 bubble 1");
    slot(1, U_F, 0, 1, 0, 0, 1, "R3 bubble 2");
    slot(1, U_F, 0, 1, 0, 1, 0, "R3 write after two bubbles");
    do_reset(1'b0);
    slot(1, U_F, 0, 1, 0, 1, 0, "R4 float write");
    slot(1, U_V, 0, 1, 0, 0, 1, "R4 write bubble 1");
    slot(1, U_V, 0, 1, 0, 0, 1, "R4 write bubble 2");
    slot(1, U_V, 0, 1, 0, 1, 0, "R4 vector write issues");
  endtask

  task automatic t_no_conflict();
    do_reset(1'b0);
    slot(1, U_V, 1, 0, 0, 1, 0, "R5 vector read");
    slot(1, U_F, 0, 1, 0, 1, 0, "R5 float write after read");
    slot(1, U_V, 1, 0, 0, 1, 0, "R5 vector read after float write");
    do_reset(1'b0);
    slot(1, U_V, 0, 1, 0, 1, 0, "R5 vector write");
    slot(1, U_F, 1, 0, 0, 1, 0, "R5 float read after write");
    do_reset(1'b0);
    slot(1, U_V, 1, 0, 0, 1, 0, "R5 same-unit read 1");
    slot(1, U_V, 1, 0, 0, 1, 0, "R5 same-unit read 2");
    slot(1, U_V, 0, 1, 0, 1, 0, "R5 same-unit write 1");
    slot(1, U_V, 0, 1, 0, 1, 0, "R5 same-unit write 2");
  endtask

  task automatic t_other_units();
    do_reset(1'b0);
    slot(1, U_V, 1, 0, 0, 1, 0, "R10 vector read");
    slot(1, U_X, 1, 0, 0, 1, 0, "R10 code 3 read not a conflict");
    slot(1, U_F, 1, 0, 0, 1, 0, "R10 other-unit read separates");
    do_reset(1'b0);
    slot(1, U_O, 0, 1, 0, 1, 0, "R10 code 0 write");
    slot(1, U_F, 0, 1, 0, 1, 0, "R10 float write after other write");
  endtask

  task automatic t_separators();
    do_reset(1'b0);
    slot(1, U_V, 1, 0, 0, 1, 0, "R6 vector read");
    slot(1, U_V, 0, 1, 0, 1, 0, "R6 coprocessor write as separator");
    slot(1, U_F, 1, 0, 0, 1, 0, "R6 float read separated");
    do_reset(1'b0);
    slot(1, U_V, 0, 1, 0, 1, 0, "R6 vector write");
    slot(1, U_V, 1, 0, 0, 1, 0, "R6 one separator");
    slot(1, U_F, 0, 1, 0, 0, 1, "R6 one separator is short");
    slot(1, U_F, 0, 1, 0, 1, 0, "R6 bubble completes separation");
    do_reset(1'b0);
    slot(1, U_V, 0, 1, 0, 1, 0, "R6 vector write");
    slot(0, U_O, 0, 0, 0, 1, 0, "R6 empty slot 1");
    slot(0, U_O, 0, 0, 0, 1, 0, "R6 empty slot 2");
    slot(1, U_F, 0, 1, 0, 1, 0, "R6 two empty slots separate");
  endtask

  task automatic t_stall();
    do_reset(1'b0);
    slot(1, U_V, 0, 1, 0, 1, 0, "R7 vector write");
    slot(1, U_F, 0, 1, 1, 0, 0, "R7 held during stall");
    slot(1, U_F, 0, 1, 1, 0, 0, "R7 held during stall 2");
    slot(1, U_F, 0, 1, 0, 0, 1, "R7 stall did not separate");
    slot(1, U_F, 0, 1, 0, 0, 1, "R7 second bubble");
    slot(1, U_F, 0, 1, 0, 1, 0, "R7 issue after bubbles");
  endtask

  task automatic t_qualified();
    do_reset(1'b1);
    slot(1, U_V, 1, 0, 0, 1, 0, "R8 vector read no stall");
    slot(1, U_F, 1, 0, 0, 1, 0, "R8 unstalled read pair allowed");
    slot(1, U_V, 0, 1, 0, 1, 0, "R8 vector write no stall");
    slot(1, U_F, 0, 1, 0, 1, 0, "R8 unstalled write pair allowed");
    do_reset(1'b1);
    slot(1, U_V, 1, 0, 0, 1, 0, "R8 vector read");
    slot(0, U_O, 0, 0, 1, 0, 0, "R8 stall marks read");
    slot(1, U_F, 1, 0, 0, 0, 1, "R8 stalled read conflicts");
    slot(1, U_F, 1, 0, 0, 1, 0, "R8 read issues after bubble");
    do_reset(1'b1);
    slot(1, U_V, 0, 1, 0, 1, 0, "R8 vector write");
    slot(0, U_O, 0, 0, 1, 0, 0, "R8 stall marks write");
    slot(1, U_F, 0, 1, 0, 0, 1, "R8 stalled write bubble 1");
    slot(1, U_F, 0, 1, 0, 0, 1, "R8 stalled write bubble 2");
    slot(1, U_F, 0, 1, 0, 1, 0, "R8 write issues");
  endtask

  task automatic t_valid_gate();
    do_reset(1'b0);
    slot(1, U_V, 0, 1, 0, 1, 0, "R9 vector write");
    slot(0, U_F, 0, 1, 0, 1, 0, "R9 invalid payload ignored");
    slot(1, U_F, 0, 1, 0, 0, 1, "R9 bubble with valid conflict");
    slot(1, U_F, 0, 1, 0, 1, 0, "R9 issue");
  endtask

  initial begin
    t_reset();
    t_read_pair();
    t_write_pair();
    t_no_conflict();
    t_other_units();
    t_separators();
    t_stall();
    t_qualified();
    t_valid_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule